// File: doc/BRIEF.md
# Receive-Word DMA Mover with Burst Buffering

This block takes data words that the terminal's protocol logic has already validated and writes them into a simple subsystem with no processor. It uses an active-low request/grant/acknowledge handshake. Each word arrives with a one-cycle strobe and is queued in a 32-entry FIFO. The mode is latched when the command is loaded. In per-word mode the block asks for the local bus as soon as a word is queued. In burst mode it holds every word until the protocol logic reports a complete, correctly sized message, then negotiates once and streams the whole block.

Every write presents a 12-bit mailbox address built from the latched command: broadcast flag, direction (always receive), subaddress and a running word index. The 16-bit data bus and an active-low write strobe go with it. If the subsystem never answers a request, a cycle-counted timer expires. The block then reports a handshake failure and drops the rest of the message. A message-error strobe or a word-count mismatch discards anything still queued.

Top module: `rxw_dma_mover`

## Requirements
- R1: After reset, req_n, ack_n, wr_n, oe_n and hs_fail_n are high, bit_hsf is low and mbox_addr is zero.
- R2: During a write, mbox_addr is {broadcast flag, 0, subaddress[4:0], word index[4:0]}, with bit 11 the broadcast flag (0 = own address) and bit 10 the direction bit, 0 for receive.
- R3: The word index is zero after each command load, rises by one after every completed write and wraps from 31 to 0.
- R4: A word transfer lasts three cycles, with ack_n low for all three. The sequence is req_n low, then ack_n low in the cycle after grant_n is seen low, then wr_n low for exactly one clock in the middle cycle. oe_n stays high, and req_n and ack_n both return high once the last acknowledge ends.
- R5: In per-word mode (cmd_burst = 0 at load), each received word costs a separate request, and the words are written in arrival order.
- R6: In burst mode (cmd_burst = 1 at load), no request is raised before msg_ok. The whole message is then written under one request, with one write strobe every three cycles.
- R7: In burst mode, a msg_ok that arrives when the queued count differs from the expected count discards the queue, and no write happens.
- R8: A msg_err strobe discards the queue, and a later msg_ok for that message starts no transfer.
- R9: If grant_n stays high for TMO_CYC cycles after req_n falls, then hs_fail_n goes low and bit_hsf goes high exactly TMO_CYC cycles after the request. At the same moment req_n is released, and further words are ignored until the next command load, which clears both flags.
- R10: The FIFO holds 32 words. A command word-count field of 0 means 32 words, and such a burst delivers all 32 with indices 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | One-cycle strobe that latches the command fields and clears the message state |
| cmd_burst | input | 1 | Mode for this message: 1 = burst, 0 = per-word |
| cmd_bcast | input | 1 | Broadcast flag of the command |
| cmd_sa | input | 5 | Subaddress of the command |
| cmd_wc | input | 5 | Word count of the command (0 = 32) |
| word_stb | input | 1 | One-cycle strobe for a validated received word |
| word_data | input | 16 | Received word that goes with word_stb |
| msg_ok | input | 1 | Strobe: message complete and valid |
| msg_err | input | 1 | Strobe: message found in error |
| grant_n | input | 1 | Bus grant from the subsystem, active low |
| req_n | output | 1 | Bus request, active low |
| ack_n | output | 1 | Transfer acknowledge, active low |
| oe_n | output | 1 | Memory output enable, active low (held high for writes) |
| wr_n | output | 1 | Memory write strobe, active low |
| mbox_addr | output | 12 | Mailbox address of the word being written |
| sys_data | output | 16 | Data word being written |
| hs_fail_n | output | 1 | Handshake failure indication, active low |
| bit_hsf | output | 1 | Handshake-failure flag for bit 12 of the self-test word |

## Verification
The bench targets four kinds of failure: a burst that starts before the message is confirmed, a burst that renegotiates between words, a word index that does not start at zero, and a word index that does not wrap at the 32-word limit. A design with any of these would show a write timed before msg_ok, more than one request, or wrong low address bits. The bench also checks that a count mismatch and a message error leave the bus silent, which catches a FIFO that is not emptied and would let stale words leak out. For the grant timeout it measures the distance from the request to the failure flag, so an off-by-one in the timer shows up. After the timeout it sends one more word and watches for a request, which exposes a design that keeps serving words after the abort.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_XA    = 3'd2,
    S_XW    = 3'd3,
    S_XE    = 3'd4,
    S_ABORT = 3'd5
  } xfer_st_t;
endpackage

// File: rtl/rxw_fifo.sv
module rxw_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + 1'b1;
      if (pop)  rd_d = rd_q + 1'b1;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  // R10
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt_q < CNTW'(DEPTH) || pop));

  // R10
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (cnt_q != '0));
endmodule

// File: rtl/rxw_grant_timer.sv
module rxw_grant_timer #(
  parameter int TMO_CYC = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYC+1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CW'(TMO_CYC-1));
endmodule

// File: rtl/rxw_dma_mover.sv
module rxw_dma_mover
  import rxw_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 32,
  parameter int SA_W    = 5,
  parameter int IDX_W   = 5,
  parameter int TMO_CYC = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_load,
  input  logic                    cmd_burst,
  input  logic                    cmd_bcast,
  input  logic [SA_W-1:0]         cmd_sa,
  input  logic [IDX_W-1:0]        cmd_wc,
  input  logic                    word_stb,
  input  logic [DATA_W-1:0]       word_data,
  input  logic                    msg_ok,
  input  logic                    msg_err,
  input  logic                    grant_n,
  output logic                    req_n,
  output logic                    ack_n,
  output logic                    oe_n,
  output logic                    wr_n,
  output logic [SA_W+IDX_W+1:0]   mbox_addr,
  output logic [DATA_W-1:0]       sys_data,
  output logic                    hs_fail_n,
  output logic                    bit_hsf
);
  localparam int CNTW = $clog2(DEPTH+1);

  xfer_st_t          st_q, st_d;
  logic              burst_q, burst_d;
  logic              bcast_q, bcast_d;
  logic [SA_W-1:0]   sa_q, sa_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNTW-1:0]   exp_q, exp_d;
  logic              go_q, go_d;
  logic              hsf_q, hsf_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic              flush, push, pop, expire, full, empty, bad_ok;
  logic [DATA_W-1:0] head;
  logic [CNTW-1:0]   count;

  rxw_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(word_data),
    .pop(pop), .dout(head), .count(count)
  );

  rxw_grant_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == S_REQ && grant_n), .expire(expire)
  );

  assign full   = (count == CNTW'(DEPTH));
  assign empty  = (count == '0);
  assign bad_ok = msg_ok && burst_q && (count != exp_q);
  assign push   = word_stb && (st_q != S_ABORT) && !full;

  always_comb begin
    st_d    = st_q;
    burst_d = burst_q;
    bcast_d = bcast_q;
    sa_d    = sa_q;
    idx_d   = idx_q;
    exp_d   = exp_q;
    go_d    = go_q;
    hsf_d   = hsf_q;
    data_d  = data_q;
    flush   = cmd_load || msg_err || bad_ok || (st_q == S_REQ && grant_n && expire);

    if (msg_ok && burst_q && !bad_ok && st_q != S_ABORT) go_d = 1'b1;
    if (msg_err) go_d = 1'b0;

    if (cmd_load) begin
      st_d    = S_IDLE;
      burst_d = cmd_burst;
      bcast_d = cmd_bcast;
      sa_d    = cmd_sa;
      idx_d   = '0;
      exp_d   = (cmd_wc == '0) ? CNTW'(DEPTH) : CNTW'(cmd_wc);
      go_d    = 1'b0;
      hsf_d   = 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (!flush && !empty && (!burst_q || go_q)) st_d = S_REQ;
        S_REQ: begin
          if (!grant_n)    st_d = S_XA;
          else if (expire) begin
            st_d  = S_ABORT;
            hsf_d = 1'b1;
          end
          else if (flush)  st_d = S_IDLE;
        end
        S_XA: st_d = S_XW;
        S_XW: st_d = S_XE;
        S_XE: begin
          idx_d = idx_q + 1'b1;
          if (burst_q && !empty && !flush) st_d = S_XA;
          else begin
            st_d = S_IDLE;
            go_d = 1'b0;
          end
        end
        S_ABORT: st_d = S_ABORT;
        default: st_d = S_IDLE;
      endcase
    end

    pop = (st_d == S_XA) && !cmd_load;
    if (pop) data_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      burst_q <= 1'b0;
      bcast_q <= 1'b0;
      sa_q    <= '0;
      idx_q   <= '0;
      exp_q   <= '0;
      go_q    <= 1'b0;
      hsf_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      burst_q <= burst_d;
      bcast_q <= bcast_d;
      sa_q    <= sa_d;
      idx_q   <= idx_d;
      exp_q   <= exp_d;
      go_q    <= go_d;
      hsf_q   <= hsf_d;
      data_q  <= data_d;
    end
  end

  assign req_n     = !(st_q inside {S_REQ, S_XA, S_XW, S_XE});
  assign ack_n     = !(st_q inside {S_XA, S_XW, S_XE});
  assign wr_n      = !(st_q == S_XW);
  assign oe_n      = 1'b1;
  assign mbox_addr = {bcast_q, 1'b0, sa_q, idx_q};
  assign sys_data  = data_q;
  assign hs_fail_n = !hsf_q;
  assign bit_hsf   = hsf_q;

  // R4
  wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> wr_n);

  // R4
  wr_inside_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!ack_n && !req_n && oe_n));

  // R4
  ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!grant_n));

  // R9
  hs_release_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> (req_n && ack_n));

  // R6
  burst_no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_n) && burst_q) |-> go_q);
endmodule

// File: tb/rxw_dma_mover_bench.sv
module rxw_dma_mover_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_load = 1'b0, cmd_burst = 1'b0, cmd_bcast = 1'b0;
  logic [4:0]  cmd_sa = '0, cmd_wc = '0;
  logic        word_stb = 1'b0;
  logic [15:0] word_data = '0;
  logic        msg_ok = 1'b0, msg_err = 1'b0;
  logic        grant_n = 1'b1;
  logic        req_n, ack_n, oe_n, wr_n, hs_fail_n, bit_hsf;
  logic [11:0] mbox_addr;
  logic [15:0] sys_data;

  always #4 clk = ~clk;

  rxw_dma_mover u_rxw_dma_mover (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_burst(cmd_burst),
    .cmd_bcast(cmd_bcast), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .word_stb(word_stb),
    .word_data(word_data), .msg_ok(msg_ok), .msg_err(msg_err), .grant_n(grant_n),
    .req_n(req_n), .ack_n(ack_n), .oe_n(oe_n), .wr_n(wr_n), .mbox_addr(mbox_addr),
    .sys_data(sys_data), .hs_fail_n(hs_fail_n), .bit_hsf(bit_hsf)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // subsystem grant responder
  int  gdelay = 0, gwait = 0;
  bit  gnever = 1'b0;
  always @(negedge clk) begin
    if (!req_n && ack_n) begin
      if (!gnever && gwait >= gdelay) grant_n <= 1'b0;
      gwait <= gwait + 1;
    end else if (req_n) begin
      grant_n <= 1'b1;
      gwait   <= 0;
    end
  end

  // write monitor
  int          cyc = 0, wr_cnt = 0, negs = 0, req_cyc = 0, hs_cyc = 0;
  logic [11:0] wr_addr [64];
  logic [15:0] wr_dat  [64];
  int          wr_cyc  [64];
  logic        prev_req = 1'b1, prev_wr = 1'b1, prev_hs = 1'b1;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && !wr_n) begin
      if (wr_cnt < 64) begin
        wr_addr[wr_cnt] <= mbox_addr;
        wr_dat[wr_cnt]  <= sys_data;
        wr_cyc[wr_cnt]  <= cyc;
      end
      wr_cnt <= wr_cnt + 1;
      chk("R4 ack low during write", 32'(ack_n), 0);
      chk("R4 oe high during write", 32'(oe_n), 1);
      chk("R4 write strobe one cycle", 32'(prev_wr), 1);
    end
    if (prev_req && !req_n) begin
      negs    <= negs + 1;
      req_cyc <= cyc;
    end
    if (prev_hs && !hs_fail_n) hs_cyc <= cyc;
    prev_req <= req_n;
    prev_wr  <= wr_n;
    prev_hs  <= hs_fail_n;
  end

  task automatic send_cmd(bit b, bit bc, logic [4:0] sa, logic [4:0] wc);
    @(negedge clk);
    cmd_burst = b; cmd_bcast = bc; cmd_sa = sa; cmd_wc = wc; cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic send_word(logic [15:0] d);
    @(negedge clk);
    word_data = d; word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
  endtask

  task automatic pulse_ok();
    @(negedge clk); msg_ok = 1'b1;
    @(negedge clk); msg_ok = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); msg_err = 1'b1;
    @(negedge clk); msg_err = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    wr_cnt = 0; negs = 0;
  endtask

  // vector table: mode, broadcast, subaddress, word count, grant delay
  localparam int NV = 6;
  localparam int VB [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int VC [NV] = '{0, 1, 0, 1, 0, 0};
  localparam int VS [NV] = '{3, 17, 1, 30, 31, 9};
  localparam int VW [NV] = '{2, 4, 5, 3, 1, 8};
  localparam int VG [NV] = '{0, 3, 1, 4, 2, 0};

  initial begin
    repeat (1000000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_n", 32'(req_n), 1);
    chk("R1 ack_n", 32'(ack_n), 1);
    chk("R1 wr_n", 32'(wr_n), 1);
    chk("R1 oe_n", 32'(oe_n), 1);
    chk("R1 hs_fail_n", 32'(hs_fail_n), 1);
    chk("R1 bit_hsf", 32'(bit_hsf), 0);
    chk("R1 mbox_addr", 32'(mbox_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int ok_cyc;
      gdelay = VG[v];
      clear_mon();
      send_cmd(VB[v] != 0, VC[v] != 0, 5'(VS[v]), 5'(VW[v]));
      for (int i = 0; i < VW[v]; i++) begin
        send_word(16'((v << 12) + i * 37 + 5));
        repeat (VB[v] != 0 ? 1 : 11) @(negedge clk);
      end
      ok_cyc = cyc;
      pulse_ok();
      repeat (20 + 4 * VW[v]) @(negedge clk);
      chk("R5 R6 write count", 32'(wr_cnt), 32'(VW[v]));
      chk("R5 R6 request count", 32'(negs), (VB[v] != 0) ? 1 : 32'(VW[v]));
      for (int i = 0; i < VW[v] && i < wr_cnt; i++) begin
        chk("R2 R3 mailbox address", 32'(wr_addr[i]),
            32'({VC[v][0], 1'b0, 5'(VS[v]), 5'(i)}));
        chk("R5 data order", 32'(wr_dat[i]), 32'(16'((v << 12) + i * 37 + 5)));
        if (VB[v] != 0 && i > 0)
          chk("R6 three cycles per word", 32'(wr_cyc[i] - wr_cyc[i-1]), 3);
      end
      if (VB[v] != 0 && wr_cnt > 0)
        chk("R6 no write before msg_ok", 32'(wr_cyc[0] > ok_cyc), 1);
      chk("R4 outputs idle after message", 32'({req_n, ack_n, wr_n}), 32'h7);
    end

    // R10: full 32-word burst with word count 0
    gdelay = 1;
    clear_mon();
    send_cmd(1'b1, 1'b0, 5'd5, 5'd0);
    for (int i = 0; i < 32; i++) send_word(16'(16'hC000 + i));
    pulse_ok();
    repeat (140) @(negedge clk);
    chk("R10 32 words written", 32'(wr_cnt), 32);
    chk("R10 one request", 32'(negs), 1);
    chk("R3 R10 last index 31", 32'(wr_addr[31]), 32'({1'b0, 1'b0, 5'd5, 5'd31}));
    chk("R10 last data", 32'(wr_dat[31]), 32'h0000C01F);
    chk("R6 burst pacing at end", 32'(wr_cyc[31] - wr_cyc[30]), 3);
    // R3: index wraps back to 0 after 32 writes
    chk("R3 index wraps", 32'(mbox_addr[4:0]), 0);

    // R7: count mismatch discards the queue
    clear_mon();
    send_cmd(1'b1, 1'b0, 5'd2, 5'd4);
    for (int i = 0; i < 3; i++) send_word(16'(16'h7700 + i));
    pulse_ok();
    repeat (30) @(negedge clk);
    chk("R7 no write on mismatch", 32'(wr_cnt), 0);
    chk("R7 no request on mismatch", 32'(negs), 0);

    // R8: message error discards the queue
    clear_mon();
    send_cmd(1'b1, 1'b0, 5'd2, 5'd3);
    for (int i = 0; i < 3; i++) send_word(16'(16'h6600 + i));
    pulse_err();
    pulse_ok();
    repeat (30) @(negedge clk);
    chk("R8 no write after error", 32'(wr_cnt), 0);
    chk("R8 no request after error", 32'(negs), 0);

    // R9: grant timeout
    gnever = 1'b1;
    clear_mon();
    send_cmd(1'b0, 1'b0, 5'd7, 5'd2);
    send_word(16'h1234);
    repeat (180) @(negedge clk);
    chk("R9 hs_fail_n low", 32'(hs_fail_n), 0);
    chk("R9 bit_hsf high", 32'(bit_hsf), 1);
    chk("R9 request released", 32'(req_n), 1);
    chk("R9 no write", 32'(wr_cnt), 0);
    chk("R9 timeout distance", 32'(hs_cyc - req_cyc), 160);
    gnever = 1'b0;
    send_word(16'h4321);
    repeat (20) @(negedge clk);
    chk("R9 word ignored after abort", 32'(negs), 1);
    send_cmd(1'b0, 1'b0, 5'd7, 5'd1);
    @(negedge clk);
    chk("R9 flags cleared by command", 32'({hs_fail_n, bit_hsf}), 32'h2);
    clear_mon();
    send_word(16'hBEEF);
    repeat (15) @(negedge clk);
    chk("R9 service resumes", 32'(wr_cnt), 1);
    chk("R9 resumed data", 32'(wr_dat[0]), 32'h0000BEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule